// File: doc/BRIEF.md
# Zigzag Reorder and Run-Length Coder

This block takes one 8x8 block of quantized transform coefficients, presented in raster order over a valid/ready input, and stores it in a 64-entry buffer. Once the block is complete, it reads the buffer back in zigzag order through an address translation table. The reordered sequence is collapsed into pairs: a coefficient value followed by the number of consecutive times that value repeats.

Runs of any value are coded, so nonzero runs are collapsed as well as zero runs. Every block produces a frame of exactly 128 output words on a valid/ready output. Zero words follow the last pair up to the end of the frame, and a last flag marks the final word. Each block is coded on its own, with no state carried from one block to the next. The input stays closed from the moment the 64th coefficient is taken until the whole frame has been sent.

Top module: `zrl_top`

## Requirements
- R1: While reset is asserted and directly after it, `in_ready` is 1 and `out_valid` is 0.
- R2: Exactly 64 coefficients are accepted per block, with raster index row*8+col. `in_ready` goes low after the 64th accept and stays low while the output frame is active, so `in_ready` and `out_valid` are never high together.
- R3: Coefficients are read back in standard JPEG zigzag order, starting with raster indices 0, 1, 8, 16, 9, 2, 3, 10, 17, 24.
- R4: Frame words at even positions (0, 2, ...) carry a coefficient value. The word that follows each one carries the length of the maximal run of that value in the zigzag sequence, and this holds for any value, not only zero.
- R5: Each count word lies in 1..64, is zero-extended to the word width, and the counts of one frame sum to 64.
- R6: After the last pair, every remaining word of the frame is 0.
- R7: Each frame has exactly 128 words, and `out_last` is 1 on word 127 and only there. The input reopens in the cycle after that word is taken.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values.
- R9: `in_data` offered while `in_ready` is 0 is ignored and does not alter the next frame.
- R10: Values are 12-bit two's complement and are passed through unchanged, including negative values.
- R11: Runs never span blocks. Two identical constant blocks give two frames, each holding one pair with a count of 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Coefficient offered |
| in_ready | output | 1 | Block accepts a coefficient |
| in_data | input | COEF_W | Signed coefficient, raster order |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | COEF_W | Value, count or pad word |
| out_last | output | 1 | Marks word 127 of the frame |

## Verification
The bench builds the block with its default parameters: 12-bit coefficients on an 8x8 grid, giving 64-entry blocks and 128-word frames. At this size a ramp block produces the worst case of 64 single runs, in which the last flag falls on a count word and no padding follows. At the other extreme, constant blocks produce a single pair followed by 126 pad words. Random back-pressure on the output stalls every state of the frame, including the count word that closes a run and the final pad word.

// File: rtl/zrl_pkg.sv
package zrl_pkg;
    typedef enum logic [2:0] {
        S_LOAD,
        S_START,
        S_RUN,
        S_EMV,
        S_EMC,
        S_PAD
    } phase_e;
endpackage

// File: rtl/zrl_zigzag_map.sv
module zrl_zigzag_map #(
    parameter int SIDE = 8,
    localparam int NUM = SIDE * SIDE,
    localparam int AW = $clog2(NUM)
) (
    input  logic [AW-1:0] zz_idx,
    output logic [AW-1:0] buf_addr
);
    // walk the anti-diagonals step by step and return the raster address
    function automatic int walk(input int k);
        int r;
        int c;
        r = 0;
        c = 0;
        for (int s = 0; s < k; s++) begin
            if (((r + c) % 2) == 0) begin
                if (c == SIDE - 1) r++;
                else if (r == 0) c++;
                else begin r--; c++; end
            end else begin
                if (r == SIDE - 1) c++;
                else if (c == 0) r++;
                else begin r++; c--; end
            end
        end
        return r * SIDE + c;
    endfunction

    logic [AW-1:0] lut [NUM];

    for (genvar k = 0; k < NUM; k++) begin : g_lut
        assign lut[k] = AW'(walk(k));
    end

    assign buf_addr = lut[zz_idx];
endmodule

// File: rtl/zrl_blk_buf.sv
module zrl_blk_buf #(
    parameter int W = 12,
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/zrl_top.sv
module zrl_top #(
    parameter int COEF_W = 12,
    parameter int SIDE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [COEF_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [COEF_W-1:0] out_data,
    output logic              out_last
);
    import zrl_pkg::*;

    localparam int NUM   = SIDE * SIDE;
    localparam int AW    = $clog2(NUM);
    localparam int KW    = AW + 1;
    localparam int FRAME = 2 * NUM;
    localparam int OW    = $clog2(FRAME);

    typedef struct packed {
        phase_e            st;
        logic [KW-1:0]     wr_idx;
        logic [KW-1:0]     rd_k;
        logic [COEF_W-1:0] val;
        logic [KW-1:0]     cnt;
        logic [OW-1:0]     out_idx;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              wr_en;
    logic [AW-1:0]     rd_addr;
    logic [COEF_W-1:0] coef;
    logic              fire;
    logic              scan_end;

    zrl_zigzag_map #(.SIDE(SIDE)) u_map (
        .zz_idx  (ctl_q.rd_k[AW-1:0]),
        .buf_addr(rd_addr)
    );

    zrl_blk_buf #(.W(COEF_W), .DEPTH(NUM)) u_buf (
        .clk  (clk),
        .we   (wr_en),
        .waddr(ctl_q.wr_idx[AW-1:0]),
        .wdata(in_data),
        .raddr(rd_addr),
        .rdata(coef)
    );

    always_comb begin
        in_ready  = (ctl_q.st == S_LOAD);
        wr_en     = in_valid && in_ready;
        out_valid = (ctl_q.st == S_EMV) || (ctl_q.st == S_EMC) || (ctl_q.st == S_PAD);
        case (ctl_q.st)
            S_EMV:   out_data = ctl_q.val;
            S_EMC:   out_data = {{(COEF_W-KW){1'b0}}, ctl_q.cnt};
            default: out_data = '0;
        endcase
        out_last = out_valid && (ctl_q.out_idx == OW'(FRAME - 1));
        fire     = out_valid && out_ready;
        scan_end = (ctl_q.rd_k == KW'(NUM));

        ctl_d = ctl_q;
        case (ctl_q.st)
            S_LOAD: begin
                if (wr_en) begin
                    if (ctl_q.wr_idx == KW'(NUM - 1)) begin
                        ctl_d.wr_idx = '0;
                        ctl_d.st     = S_START;
                    end else begin
                        ctl_d.wr_idx = ctl_q.wr_idx + 1'b1;
                    end
                end
            end
            S_START: begin
                ctl_d.val  = coef;
                ctl_d.cnt  = KW'(1);
                ctl_d.rd_k = KW'(1);
                ctl_d.st   = S_RUN;
            end
            S_RUN: begin
                if (scan_end || (coef != ctl_q.val)) begin
                    ctl_d.st = S_EMV;
                end else begin
                    ctl_d.cnt  = ctl_q.cnt + 1'b1;
                    ctl_d.rd_k = ctl_q.rd_k + 1'b1;
                end
            end
            S_EMV: begin
                if (fire) begin
                    ctl_d.out_idx = ctl_q.out_idx + 1'b1;
                    ctl_d.st      = S_EMC;
                end
            end
            S_EMC: begin
                if (fire) begin
                    ctl_d.out_idx = ctl_q.out_idx + 1'b1;
                    if (scan_end) begin
                        ctl_d.st = out_last ? S_LOAD : S_PAD;
                    end else begin
                        ctl_d.val  = coef;
                        ctl_d.cnt  = KW'(1);
                        ctl_d.rd_k = ctl_q.rd_k + 1'b1;
                        ctl_d.st   = S_RUN;
                    end
                end
            end
            S_PAD: begin
                if (fire) begin
                    ctl_d.out_idx = ctl_q.out_idx + 1'b1;
                    if (out_last) ctl_d.st = S_LOAD;
                end
            end
            default: ctl_d.st = S_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st      <= S_LOAD;
            ctl_q.wr_idx  <= '0;
            ctl_q.rd_k    <= '0;
            ctl_q.val     <= '0;
            ctl_q.cnt     <= '0;
            ctl_q.out_idx <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // R2
    hs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    // R2
    blk_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctl_q.wr_idx == KW'(NUM - 1)) |=> !in_ready);

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R7
    last_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && out_last) |=> (in_ready && !out_valid));

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == S_EMC) |-> (ctl_q.cnt != '0 && ctl_q.cnt <= KW'(NUM)));
endmodule

// File: tb/tb_zrl_top.sv
`timescale 1ns/1ps
module tb_zrl_top;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [W-1:0] out_data;
    logic         out_last;

    always #2.5 clk = ~clk;

    zrl_top dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    typedef struct {
        logic [W-1:0] d;
        logic         l;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   errors = 0;
    int   checks = 0;
    logic mon_en = 1'b0;
    logic stall_q = 1'b0;
    logic [W-1:0] stall_data;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [W-1:0] d, input string tag);
        exp_t e;
        e.d = d;
        e.l = 1'b0;
        e.tag = tag;
        q.push_back(e);
    endtask

    // expected frame from the requirements, then drive the block
    task automatic send_block(input logic signed [W-1:0] blk [64], input string vtag);
        logic signed [W-1:0] zz [64];
        int n;
        int i;
        int base;
        n = 0;
        for (int s = 0; s < 15; s++) begin
            int lo;
            int hi;
            lo = (s > 7) ? s - 7 : 0;
            hi = (s < 7) ? s : 7;
            if (s % 2 == 0) begin
                for (int r = hi; r >= lo; r--) begin zz[n] = blk[r*8 + (s-r)]; n++; end
            end else begin
                for (int r = lo; r <= hi; r++) begin zz[n] = blk[r*8 + (s-r)]; n++; end
            end
        end
        base = q.size();
        i = 0;
        while (i < 64) begin
            int len;
            len = 1;
            while (i + len < 64 && zz[i+len] == zz[i]) len++;
            push(zz[i], vtag);
            push(W'(len), "R5");
            i += len;
        end
        while (q.size() - base < 128) push('0, "R6");
        q[q.size()-1].l = 1'b1;

        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = blk[k];
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R2 in_ready after 64th accept", in_ready, 0);
    endtask

    // monitor / scoreboard and back-pressure
    always @(negedge clk) begin
        if (mon_en) begin
            if (stall_q) begin
                chk(out_valid == 1'b1, "R8 valid held", out_valid, 1);
                chk(out_data == stall_data, "R8 data held", out_data, stall_data);
            end
            out_ready = ($urandom % 10) < 7;
            if (out_valid) chk(!in_ready, "R2 exclusive", in_ready, 0);
            if (out_valid && out_ready) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R7 extra word", out_data, -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(out_data == e.d, e.tag, $signed(out_data), $signed(e.d));
                    chk(out_last == e.l, "R7 last flag", out_last, e.l);
                end
            end
            stall_q = out_valid && !out_ready;
            stall_data = out_data;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic signed [W-1:0] b [64];
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        mon_en = 1'b1;

        // R3: ramp block, all runs of length 1, worst-case frame
        for (int k = 0; k < 64; k++) b[k] = W'(k);
        send_block(b, "R3");

        // R9: garbage offered while the input is closed
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 12'h7FF;
        end

        // R6 R9: all-zero block
        for (int k = 0; k < 64; k++) b[k] = '0;
        send_block(b, "R6 R9");

        // R4: row-valued block including negatives
        for (int k = 0; k < 64; k++) b[k] = W'((k / 8) - 3);
        send_block(b, "R4");

        // R10 R11: two identical negative constant blocks
        for (int k = 0; k < 64; k++) b[k] = -12'sd5;
        send_block(b, "R10");
        send_block(b, "R11");

        // R4: nonzero runs broken by sparse values
        for (int k = 0; k < 64; k++) b[k] = (k % 5 == 0) ? 12'sd1 : 12'sd7;
        send_block(b, "R4");

        while (q.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(in_ready == 1'b1, "R7 input reopened", in_ready, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule